// File: doc/BRIEF.md
# Downstream Port Power Controller

This block drives the enables of the power switches for the downstream ports of a hub and watches the active-low over-current outputs of those switches. The port-state logic of the hub raises a per-port power request in place of the host's set and clear port-power commands. The controller turns each request into a switch enable and reports over-current faults back to the hub status logic. Each fault is reported as a live status bit and as a sticky change flag.

Three strap pins are captured when reset is released. The first selects the enable polarity. The second selects individual or ganged power policy. The third turns power management off altogether. In individual mode every port is powered and tripped on its own. In ganged mode all ports share one switch state: power stays on while any port asks for it, and a fault on any input removes power from every port. Each over-current input passes through a two-flop synchronizer and must stay low for `OC_QUAL_CYC` consecutive cycles before a fault is declared. A tripped port is not repowered until its request has been dropped and raised again.

Top module: `hub_port_pwr_ctrl`

## Requirements
- R1: Individual mode (ganged strap 0): port i is enabled exactly when its request `pwr_req_i[i]` is high and the port is not tripped. The change appears one clock after the request changes.
- R2: Individual mode: a qualified over-current on port i switches off port i only, sets `oc_status_o` and `oc_chg_o` for port i only, and leaves the other ports powered.
- R3: Ganged mode (ganged strap 1): all ports are enabled while at least one request is high. All ports are disabled only when every request is low.
- R4: Ganged mode: a qualified over-current on any single input, with the other inputs left high, disables every port and sets `oc_status_o` and `oc_chg_o` for every port.
- R5: Over-current inputs are active low (0 = fault, 1 = no fault). A low level seen for fewer than `OC_QUAL_CYC` consecutive clocks is ignored. A level seen for at least that many clocks declares a fault.
- R6: The polarity strap is captured at reset release. With 1 an enabled port drives 1; with 0 it drives 0. Later changes on any strap pin have no effect.
- R7: With the power-management strap at 1, every enable stays at its inactive level whatever the requests are. Over-current inputs are then ignored: status and change flags stay 0.
- R8: `oc_chg_o[i]` is set when port i's fault is declared. It stays set after the fault goes away, until a one-cycle pulse on `oc_clr_i[i]`.
- R9: After a trip, a port stays off after the fault clears, even with its request still high. It is repowered only after the request goes low and then high again.
- R10: While `rst_ni` is low, every enable drives its inactive level, which is the inverse of the polarity strap pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_pol_hi_i | input | 1 | Enable polarity strap (1 = active high) |
| strap_ganged_i | input | 1 | Power policy strap (1 = ganged) |
| strap_pm_off_i | input | 1 | Power management disable strap (1 = off) |
| pwr_req_i | input | NPORT | Per-port power request from port-state logic |
| oc_n_i | input | NPORT | Over-current inputs, active low |
| oc_clr_i | input | NPORT | One-cycle clear of the sticky change flags |
| pwr_en_o | output | NPORT | Switch enables, polarity per strap |
| oc_status_o | output | NPORT | Live qualified over-current per port |
| oc_chg_o | output | NPORT | Sticky over-current change flags |

## Verification
The hardest state to reach is the trip latch. A port that is off because it tripped has to be told apart from a port that is off because it was never asked. This matters most after the fault input has gone high again and the request is still held. The bench first holds the request, then pulses each over-current input, then releases the input. It checks that the port stays dark, and only then drops and re-raises the request. It repeats this for every port under each polarity and policy. It also sweeps the low-pulse length across the qualification threshold, so that a pulse one cycle too short must leave no trace.

// File: rtl/hpp_pkg.sv
package hpp_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_ON   = 2'd1,
    PS_TRIP = 2'd2
  } port_st_e;

  typedef struct packed {
    logic pol_hi;
    logic ganged;
    logic pm_off;
  } strap_cfg_t;

endpackage

// File: rtl/hpp_rst_sync.sv
module hpp_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/hpp_strap_latch.sv
module hpp_strap_latch
  import hpp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  strap_cfg_t pins_i,
  output strap_cfg_t cfg_o
);

  logic       cap_q;
  logic       cap_d;
  strap_cfg_t cfg_q;
  strap_cfg_t cfg_d;

  // Capture once, on the first edge after reset release.
  always_comb begin
    cap_d = 1'b1;
    cfg_d = cfg_q;
    if (!cap_q) begin
      cfg_d = pins_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      cap_q <= cap_d;
      cfg_q <= cfg_d;
    end
  end

  // Until the capture edge the pins themselves are in force.
  assign cfg_o = cap_q ? cfg_q : pins_i;

endmodule

// File: rtl/hpp_oc_qual.sv
module hpp_oc_qual #(
  parameter int unsigned QUAL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_ni,
  output logic det_o
);

  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_CYC);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], oc_ni};
    end
  end

  // Count consecutive low samples, saturating at the threshold.
  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (sync_q[1]) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign det_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/hpp_port_fsm.sv
module hpp_port_fsm
  import hpp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic fault_i,
  input  logic hold_off_i,
  output logic on_o
);

  port_st_e st_q;
  port_st_e st_d;

  always_comb begin
    st_d = st_q;
    if (hold_off_i) begin
      st_d = PS_OFF;
    end else begin
      unique case (st_q)
        PS_OFF:  if (req_i && !fault_i) st_d = PS_ON;
        PS_ON: begin
          if (fault_i)     st_d = PS_TRIP;
          else if (!req_i) st_d = PS_OFF;
        end
        PS_TRIP: if (!req_i) st_d = PS_OFF;
        default: st_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= PS_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  assign on_o = (st_q == PS_ON);

endmodule

// File: rtl/hub_port_pwr_ctrl.sv
module hub_port_pwr_ctrl
  import hpp_pkg::*;
#(
  parameter int unsigned NPORT       = 4,
  parameter int unsigned OC_QUAL_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strap_pol_hi_i,
  input  logic             strap_ganged_i,
  input  logic             strap_pm_off_i,
  input  logic [NPORT-1:0] pwr_req_i,
  input  logic [NPORT-1:0] oc_n_i,
  input  logic [NPORT-1:0] oc_clr_i,
  output logic [NPORT-1:0] pwr_en_o,
  output logic [NPORT-1:0] oc_status_o,
  output logic [NPORT-1:0] oc_chg_o
);

  logic             rst_n_int;
  strap_cfg_t       pins;
  strap_cfg_t       cfg;
  logic [NPORT-1:0] det;
  logic [NPORT-1:0] fault_eff;
  logic [NPORT-1:0] port_on;
  logic [NPORT-1:0] act;
  logic [NPORT-1:0] fault_q;
  logic [NPORT-1:0] chg_q;
  logic [NPORT-1:0] chg_d;

  hpp_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  assign pins = '{pol_hi: strap_pol_hi_i, ganged: strap_ganged_i, pm_off: strap_pm_off_i};

  hpp_strap_latch u_strap (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .pins_i (pins),
    .cfg_o  (cfg)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    hpp_oc_qual #(.QUAL_CYC(OC_QUAL_CYC)) u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_n_int),
      .oc_ni  (oc_n_i[i]),
      .det_o  (det[i])
    );

    hpp_port_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_n_int),
      .req_i      (pwr_req_i[i]),
      .fault_i    (fault_eff[i]),
      .hold_off_i (cfg.pm_off),
      .on_o       (port_on[i])
    );
  end

  // Fault routing and enable policy.
  always_comb begin
    if (cfg.pm_off) begin
      fault_eff = '0;
      act       = '0;
    end else if (cfg.ganged) begin
      fault_eff = {NPORT{|det}};
      act       = {NPORT{|port_on}};
    end else begin
      fault_eff = det;
      act       = port_on;
    end
  end

  // Sticky change flags: a new fault wins over a clear in the same cycle.
  always_comb begin
    chg_d = (chg_q & ~oc_clr_i) | (fault_eff & ~fault_q);
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      fault_q <= '0;
      chg_q   <= '0;
    end else begin
      fault_q <= fault_eff;
      chg_q   <= chg_d;
    end
  end

  assign pwr_en_o    = cfg.pol_hi ? act : ~act;
  assign oc_status_o = fault_eff;
  assign oc_chg_o    = chg_q;

endmodule

// File: rtl/hpp_chk.sv
module hpp_chk #(
  parameter int unsigned NPORT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pol_hi,
  input logic             ganged,
  input logic             pm_off,
  input logic [NPORT-1:0] oc_clr_i,
  input logic [NPORT-1:0] pwr_en_o,
  input logic [NPORT-1:0] oc_status_o,
  input logic [NPORT-1:0] oc_chg_o
);

  logic [NPORT-1:0] lit;
  assign lit = pol_hi ? pwr_en_o : ~pwr_en_o;

  // R7
  pm_off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_off |-> (lit == '0 && oc_status_o == '0));

  // R3
  gang_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ganged && !pm_off) |-> ($countones(lit) == 0 || $countones(lit) == NPORT));

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R2
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oc_status_o[i] |=> !lit[i]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_chg_o[i] && !oc_clr_i[i]) |=> oc_chg_o[i]);

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oc_chg_o[i]) |-> $past(oc_status_o[i]));
  end

endmodule

bind hub_port_pwr_ctrl hpp_chk #(.NPORT(NPORT)) u_hpp_chk (
  .clk         (clk_i),
  .rst_n       (rst_n_int),
  .pol_hi      (cfg.pol_hi),
  .ganged      (cfg.ganged),
  .pm_off      (cfg.pm_off),
  .oc_clr_i    (oc_clr_i),
  .pwr_en_o    (pwr_en_o),
  .oc_status_o (oc_status_o),
  .oc_chg_o    (oc_chg_o)
);

// File: tb/test_hub_port_pwr_ctrl.sv
module test_hub_port_pwr_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int QUAL = 4;
  localparam logic [NP-1:0] ALL = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          s_pol, s_gang, s_pm;
  logic [NP-1:0] req, oc_n, clr;
  logic [NP-1:0] en, st, chg;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;
  logic          cur_pol;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_port_pwr_ctrl #(.NPORT(NP), .OC_QUAL_CYC(QUAL)) i_hub_port_pwr_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .strap_pol_hi_i(s_pol), .strap_ganged_i(s_gang), .strap_pm_off_i(s_pm),
    .pwr_req_i(req), .oc_n_i(oc_n), .oc_clr_i(clr),
    .pwr_en_o(en), .oc_status_o(st), .oc_chg_o(chg)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] pins(input logic [NP-1:0] on);
    return cur_pol ? on : ~on;
  endfunction

  task automatic do_reset(input logic pol, input logic gang, input logic pm);
    @(negedge clk);
    s_pol = pol; s_gang = gang; s_pm = pm; cur_pol = pol;
    req = '0; oc_n = ALL; clr = '0;
    rst_n = 1'b0;
    tick(3);
    chk("R10 enables inactive in reset", en, pins('0));
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic recover(input logic [NP-1:0] rq);
    oc_n = ALL; tick(6);
    clr = ALL; tick(1); clr = '0;
    req = '0; tick(2);
    req = rq; tick(2);
  endtask

  initial begin
    rst_n = 1'b0; s_pol = 1'b1; s_gang = 1'b0; s_pm = 1'b0; cur_pol = 1'b1;
    req = '0; oc_n = ALL; clr = '0;

    for (int pol = 0; pol < 2; pol++) begin
      for (int gang = 0; gang < 2; gang++) begin
        do_reset(pol[0], gang[0], 1'b0);
        chk("R10 after reset idle", en, pins('0));
        // R1 / R3: request sweep
        for (int p = 0; p < 16; p++) begin
          req = p[NP-1:0]; tick(2);
          if (gang == 0) chk("R1 individual follows request", en, pins(p[NP-1:0]));
          else           chk("R3 ganged any-request", en, pins((p != 0) ? ALL : '0));
        end
        // R6: strap pins ignored after capture
        req = 4'b0101; tick(2);
        s_pol = ~s_pol; s_gang = ~s_gang; s_pm = 1'b1; tick(3);
        chk("R6 straps frozen", en, pins(gang ? ALL : 4'b0101));
        s_pol = cur_pol; s_gang = gang[0]; s_pm = 1'b0;
        // R2 / R4 / R8 / R9: fault on each port
        for (int p = 0; p < NP; p++) begin
          req = ALL; tick(2);
          oc_n[p] = 1'b0; tick(QUAL + 4);
          if (gang == 0) begin
            chk("R2 isolated trip enables", en, pins(ALL & ~(4'b1 << p)));
            chk("R2 status one port", st, 4'b1 << p);
            chk("R2 flag one port", chg, 4'b1 << p);
          end else begin
            chk("R4 ganged trip all off", en, pins('0));
            chk("R4 status all", st, ALL);
            chk("R4 flag all", chg, ALL);
          end
          oc_n = ALL; tick(6);
          chk("R8 flag sticky after fault gone", chg, gang ? ALL : (4'b1 << p));
          chk("R9 stays off while request held", en, pins(gang ? '0 : (ALL & ~(4'b1 << p))));
          clr = ALL; tick(1); clr = '0; tick(1);
          chk("R8 clear pulse", chg, '0);
          if (gang == 0) req[p] = 1'b0; else req = '0;
          tick(2);
          req = ALL; tick(2);
          chk("R9 repowered after re-request", en, pins(ALL));
        end
      end
    end

    // R5: qualification threshold sweep (individual, active high)
    do_reset(1'b1, 1'b0, 1'b0);
    req = ALL; tick(2);
    for (int len = 1; len <= QUAL + 2; len++) begin
      oc_n[0] = 1'b0; tick(len); oc_n[0] = 1'b1; tick(8);
      chk("R5 pulse length qualification", chg, (len >= QUAL) ? 4'b0001 : 4'b0000);
      chk("R5 enable after pulse", en, (len >= QUAL) ? 4'b1110 : ALL);
      recover(ALL);
    end

    // R7: power management off
    for (int pol = 0; pol < 2; pol++) begin
      do_reset(pol[0], 1'b0, 1'b1);
      req = ALL; tick(3);
      chk("R7 enables inactive", en, pins('0));
      oc_n = '0; tick(QUAL + 5);
      chk("R7 status ignored", st, '0);
      chk("R7 flags ignored", chg, '0);
      oc_n = ALL; tick(2);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule